// File: doc/BRIEF.md
# Dual-Channel Bidirectional Segment Shift-Latch Driver

This block is the digital core of an 80-output dot-matrix LCD segment driver. It holds two independent 40-stage shift registers. Each register has its own direction input and its own pair of serial pins. A display controller shifts pixel bits in serially on the falling edges of a shift strobe. On the falling edge of a latch strobe, the contents of both registers are copied in parallel into display latches. Every segment then receives a 2-bit bias-level code, formed from its latched bit and an alternation input.

The strobes, the alternation input and the serial inputs are slow, asynchronous signals. Their high and low phases last hundreds of nanoseconds. The block samples them through a synchronizer on the system clock and acts on falling edges that it detects internally, so the whole design runs in one clock domain.

When a serial pin acts as an output, it carries the bit leaving the far end of its register, so several drivers can be chained. The output enables tell the pad ring which pin of each pair is currently driving.

Top module: `seg_shift_latch_drv`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every segment code on `lvl_o` is 2'b10, and all four serial outputs are 0.
- R2: With `dir_i[c]`=0, channel c takes its serial input from `ser_l_i[c]`. On each shift the new bit enters the lowest segment of the channel (segment 0 or 40, counting from 0), and every bit moves up one segment.
- R3: With `dir_i[c]`=1, channel c takes its serial input from `ser_r_i[c]`. On each shift the new bit enters the highest segment of the channel (segment 39 or 79), and every bit moves down one segment.
- R4: Registers shift exactly once per falling edge of `shift_strb_i`. A rising edge, or a strobe held steady, moves nothing.
- R5: On a falling edge of `latch_strb_i`, both registers are copied into the latches. Between latch edges, `lvl_o` does not change except through the alternation input, however much shifting occurs.
- R6: Segment k's code sits at `lvl_o[2k+1:2k]`. It is 00 for latched 1 with alt 0, 01 for latched 1 with alt 1, 10 for latched 0 with alt 0, and 11 for latched 0 with alt 1.
- R7: `ser_l_oe[c]` equals `dir_i[c]` and `ser_r_oe[c]` equals its inverse. A serial output whose enable is low reads 0.
- R8: The enabled serial output of channel c presents the register bit at the exit end. That is segment 39 (within the channel) for direction 0, and segment 0 for direction 1.
- R9: When a latch falling edge and a shift falling edge are detected in the same cycle, the latches take the register contents from before that shift.
- R10: The two channels shift independently. Each one follows its own direction bit and its own serial pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_strb_i | input | 1 | Asynchronous shift strobe, acting on its falling edge |
| latch_strb_i | input | 1 | Asynchronous latch strobe, acting on its falling edge |
| alt_i | input | 1 | Alternation input choosing between the two levels of each pair |
| dir_i | input | 2 | Per-channel direction; 0 shifts low to high, 1 shifts high to low |
| ser_l_i | input | 2 | Left serial pin input value per channel |
| ser_r_i | input | 2 | Right serial pin input value per channel |
| ser_l_o | output | 2 | Left serial pin output value per channel |
| ser_r_o | output | 2 | Right serial pin output value per channel |
| ser_l_oe | output | 2 | Left serial pin output enable per channel |
| ser_r_oe | output | 2 | Right serial pin output enable per channel |
| lvl_o | output | 160 | Two-bit bias-level code for each of the 80 segments |

## Verification
A latch falling edge and a shift falling edge can be detected in the same system-clock cycle. In that cycle the latch must capture the old register contents, not the shifted ones. The bench provokes this by releasing both strobes at the same instant, after loading the registers with a known pattern. It then compares every segment code against a reference model that latches before shifting. A further latch alone confirms that the shift also took effect. Randomized sequences repeat the coincidence with random directions and data.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    LVL_SEL_P  = 2'b00,
    LVL_SEL_N  = 2'b01,
    LVL_NSEL_P = 2'b10,
    LVL_NSEL_N = 2'b11
  } bias_lvl_e;

  function automatic bias_lvl_e pick_level(input logic on, input logic alt);
    case ({on, alt})
      2'b10:   return LVL_SEL_P;
      2'b11:   return LVL_SEL_N;
      2'b00:   return LVL_NSEL_P;
      default: return LVL_NSEL_N;
    endcase
  endfunction
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
  assign fall_o = prev_q & ~stg[STAGES-1];
endmodule

// File: rtl/segdrv_chan.sv
module segdrv_chan #(
  parameter int CH_BITS = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dir,
  input  logic               shift_en,
  input  logic               latch_en,
  input  logic               din_l,
  input  logic               din_r,
  output logic [CH_BITS-1:0] sr_q,
  output logic [CH_BITS-1:0] lat_q,
  output logic               dout_l,
  output logic               dout_r,
  output logic               oe_l,
  output logic               oe_r
);
  localparam int TOP = CH_BITS - 1;

  logic [CH_BITS-1:0] sr_next;

  always_comb begin
    if (dir) sr_next = {din_r, sr_q[TOP:1]};
    else     sr_next = {sr_q[TOP-1:0], din_l};
  end

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= sr_next;
  end

  // latch reads sr_q before the shift of the same edge lands
  always_ff @(posedge clk) begin
    if (rst)           lat_q <= '0;
    else if (latch_en) lat_q <= sr_q;
  end

  assign oe_l   = dir;
  assign oe_r   = ~dir;
  assign dout_l = dir & sr_q[0];
  assign dout_r = ~dir & sr_q[TOP];
endmodule

// File: rtl/segdrv_level_enc.sv
module segdrv_level_enc #(
  parameter int NSEG = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSEG-1:0]   lat_i,
  input  logic              alt_i,
  output logic [2*NSEG-1:0] lvl_o
);
  import segdrv_pkg::*;

  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_seg
      always_ff @(posedge clk) begin
        if (rst) lvl_o[2*k+1:2*k] <= LVL_NSEL_P;
        else     lvl_o[2*k+1:2*k] <= pick_level(lat_i[k], alt_i);
      end
    end
  endgenerate
endmodule

// File: rtl/seg_shift_latch_drv.sv
module seg_shift_latch_drv #(
  parameter int CH_BITS     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    shift_strb_i,
  input  logic                                    latch_strb_i,
  input  logic                                    alt_i,
  input  logic [segdrv_pkg::NUM_CH-1:0]           dir_i,
  input  logic [segdrv_pkg::NUM_CH-1:0]           ser_l_i,
  input  logic [segdrv_pkg::NUM_CH-1:0]           ser_r_i,
  output logic [segdrv_pkg::NUM_CH-1:0]           ser_l_o,
  output logic [segdrv_pkg::NUM_CH-1:0]           ser_r_o,
  output logic [segdrv_pkg::NUM_CH-1:0]           ser_l_oe,
  output logic [segdrv_pkg::NUM_CH-1:0]           ser_r_oe,
  output logic [2*segdrv_pkg::NUM_CH*CH_BITS-1:0] lvl_o
);
  import segdrv_pkg::*;

  localparam int NSEG   = NUM_CH * CH_BITS;
  localparam int SYNC_W = 3 + 2 * NUM_CH;

  logic [SYNC_W-1:0] sync_v, fall_v;
  logic [NUM_CH-1:0] sl_s, sr_s;
  logic              shift_fall, latch_fall, alt_s;
  logic [NSEG-1:0]   sr_all, lat_all;

  segdrv_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i({ser_r_i, ser_l_i, alt_i, latch_strb_i, shift_strb_i}),
    .sync_o (sync_v),
    .fall_o (fall_v)
  );

  assign shift_fall = fall_v[0];
  assign latch_fall = fall_v[1];
  assign alt_s      = sync_v[2];
  assign sl_s       = sync_v[3 +: NUM_CH];
  assign sr_s       = sync_v[3 + NUM_CH +: NUM_CH];

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      segdrv_chan #(.CH_BITS(CH_BITS)) u_chan (
        .clk     (clk),
        .rst     (rst),
        .dir     (dir_i[c]),
        .shift_en(shift_fall),
        .latch_en(latch_fall),
        .din_l   (sl_s[c]),
        .din_r   (sr_s[c]),
        .sr_q    (sr_all[c*CH_BITS +: CH_BITS]),
        .lat_q   (lat_all[c*CH_BITS +: CH_BITS]),
        .dout_l  (ser_l_o[c]),
        .dout_r  (ser_r_o[c]),
        .oe_l    (ser_l_oe[c]),
        .oe_r    (ser_r_oe[c])
      );
    end
  endgenerate

  segdrv_level_enc #(.NSEG(NSEG)) u_enc (
    .clk  (clk),
    .rst  (rst),
    .lat_i(lat_all),
    .alt_i(alt_s),
    .lvl_o(lvl_o)
  );
endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk #(
  parameter int CH_BITS = 40
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic                                    shift_fall,
  input logic                                    latch_fall,
  input logic [segdrv_pkg::NUM_CH*CH_BITS-1:0]   sr_all,
  input logic [segdrv_pkg::NUM_CH*CH_BITS-1:0]   lat_all,
  input logic [segdrv_pkg::NUM_CH-1:0]           ser_l_o,
  input logic [segdrv_pkg::NUM_CH-1:0]           ser_r_o,
  input logic [segdrv_pkg::NUM_CH-1:0]           ser_l_oe,
  input logic [segdrv_pkg::NUM_CH-1:0]           ser_r_oe,
  input logic [2*segdrv_pkg::NUM_CH*CH_BITS-1:0] lvl_o
);
  localparam int NSEG = segdrv_pkg::NUM_CH * CH_BITS;

  logic [2*NSEG-1:0] rst_codes;
  logic [NSEG-1:0]   alt_bits;

  always_comb begin
    for (int k = 0; k < NSEG; k++) begin
      rst_codes[2*k +: 2] = 2'b10;
      alt_bits[k]         = lvl_o[2*k];
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (lvl_o == rst_codes));

  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_fall |=> $stable(sr_all));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_fall |=> $stable(lat_all));

  // R9
  latch_preshift_chk: assert property (@(posedge clk) disable iff (rst)
    latch_fall |=> (lat_all == $past(sr_all)));

  // R6
  alt_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (alt_bits == '0) || (alt_bits == '1));

  // R7
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((ser_l_o & ~ser_l_oe) == '0) && ((ser_r_o & ~ser_r_oe) == '0)
    && ((ser_l_oe & ser_r_oe) == '0));
endmodule

bind seg_shift_latch_drv segdrv_chk #(.CH_BITS(CH_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_fall(shift_fall),
  .latch_fall(latch_fall),
  .sr_all    (sr_all),
  .lat_all   (lat_all),
  .ser_l_o   (ser_l_o),
  .ser_r_o   (ser_r_o),
  .ser_l_oe  (ser_l_oe),
  .ser_r_oe  (ser_r_oe),
  .lvl_o     (lvl_o)
);

// File: tb/tb_seg_shift_latch_drv.sv
module tb_seg_shift_latch_drv;
  localparam int CB = 40;
  localparam int NS = 2 * CB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shift_strb_i = 1'b0, latch_strb_i = 1'b0, alt_i = 1'b0;
  logic [1:0]    dir_i = 2'b00, ser_l_i = 2'b00, ser_r_i = 2'b00;
  logic [1:0]    ser_l_o, ser_r_o, ser_l_oe, ser_r_oe;
  logic [2*NS-1:0] lvl_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [CB-1:0] m_sr  [2];
  logic [CB-1:0] m_lat [2];
  logic          m_alt;

  always #10 clk = ~clk;

  seg_shift_latch_drv dut (
    .clk(clk), .rst(rst), .shift_strb_i(shift_strb_i), .latch_strb_i(latch_strb_i),
    .alt_i(alt_i), .dir_i(dir_i), .ser_l_i(ser_l_i), .ser_r_i(ser_r_i),
    .ser_l_o(ser_l_o), .ser_r_o(ser_r_o), .ser_l_oe(ser_l_oe), .ser_r_oe(ser_r_oe),
    .lvl_o(lvl_o)
  );

  function automatic logic [2*NS-1:0] exp_lvl();
    logic [2*NS-1:0] v;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < CB; i++)
        v[2*(c*CB+i) +: 2] = {~m_lat[c][i], m_alt};
    return v;
  endfunction

  function automatic logic [7:0] exp_pins();
    logic [1:0] lo, ro;
    for (int c = 0; c < 2; c++) begin
      lo[c] = dir_i[c] ? m_sr[c][0] : 1'b0;
      ro[c] = dir_i[c] ? 1'b0 : m_sr[c][CB-1];
    end
    return {lo, ro, dir_i, ~dir_i};
  endfunction

  task automatic chk_lvl(input string req);
    logic [2*NS-1:0] e;
    e = exp_lvl();
    n_chk++;
    if (lvl_o !== e) begin
      n_fail++;
      $display("FAIL %s lvl_o actual=%h expected=%h", req, lvl_o, e);
    end
  endtask

  task automatic chk_pins(input string req);
    logic [7:0] e, a;
    e = exp_pins();
    a = {ser_l_o, ser_r_o, ser_l_oe, ser_r_oe};
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s pins{lo,ro,loe,roe} actual=%b expected=%b", req, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_shift(input logic [1:0] l, input logic [1:0] r);
    for (int c = 0; c < 2; c++) begin
      if (dir_i[c]) m_sr[c] = {r[c], m_sr[c][CB-1:1]};
      else          m_sr[c] = {m_sr[c][CB-2:0], l[c]};
    end
  endtask

  // one shift strobe pulse; both serial pins carry data
  task automatic do_shift(input logic [1:0] l, input logic [1:0] r);
    @(negedge clk);
    ser_l_i = l; ser_r_i = r; shift_strb_i = 1'b1;
    idle(5);
    shift_strb_i = 1'b0;
    idle(6);
    model_shift(l, r);
  endtask

  task automatic do_latch();
    @(negedge clk);
    latch_strb_i = 1'b1;
    idle(5);
    latch_strb_i = 1'b0;
    idle(6);
    m_lat[0] = m_sr[0]; m_lat[1] = m_sr[1];
  endtask

  task automatic do_both(input logic [1:0] l, input logic [1:0] r);
    @(negedge clk);
    ser_l_i = l; ser_r_i = r; shift_strb_i = 1'b1; latch_strb_i = 1'b1;
    idle(5);
    shift_strb_i = 1'b0; latch_strb_i = 1'b0;
    idle(6);
    m_lat[0] = m_sr[0]; m_lat[1] = m_sr[1];
    model_shift(l, r);
  endtask

  task automatic set_alt(input logic a);
    @(negedge clk);
    alt_i = a;
    idle(6);
    m_alt = a;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] b;
    logic [2*NS-1:0] snap;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin m_sr[c] = '0; m_lat[c] = '0; end
    m_alt = 1'b0;

    idle(3);
    chk_lvl("R1 in reset");
    chk_pins("R1 R7 in reset");
    @(negedge clk); rst = 1'b0;
    chk_lvl("R1 after reset");

    // R2: both channels low-to-high, fill with random data
    dir_i = 2'b00;
    for (int i = 0; i < CB; i++) begin
      b = 2'($urandom());
      do_shift(b, ~b);
      chk_pins("R2 R8 dir0 exit bit");
    end
    chk_lvl("R5 no latch yet");
    do_latch();
    chk_lvl("R2 R6 latched dir0");
    set_alt(1'b1);
    chk_lvl("R6 alt high");
    set_alt(1'b0);

    // R4: rising edge alone does not shift
    snap = lvl_o;
    @(negedge clk);
    ser_l_i = 2'b11; shift_strb_i = 1'b1;
    idle(8);
    chk_pins("R4 rise no shift");
    shift_strb_i = 1'b0; idle(6);
    model_shift(2'b11, ser_r_i);
    chk_pins("R4 fall shifts once");
    chk_lvl("R5 shift without latch");

    // R3: both channels high-to-low
    dir_i = 2'b11; idle(2);
    chk_pins("R7 oe dir1");
    for (int i = 0; i < CB; i++) begin
      b = 2'($urandom());
      do_shift(~b, b);
      chk_pins("R3 R8 dir1 exit bit");
    end
    do_latch();
    chk_lvl("R3 latched dir1");

    // R10: mixed directions, distinct walking patterns
    dir_i = 2'b01; idle(2);
    chk_pins("R7 R10 mixed oe");
    for (int i = 0; i < 7; i++) begin
      do_shift({1'b0, 1'b1}, {1'b1, 1'b0});
      chk_pins("R10 mixed shift");
    end
    do_latch();
    chk_lvl("R10 mixed latch");

    // R9: coincident latch and shift
    do_both(2'b11, 2'b11);
    chk_lvl("R9 latch before shift");
    do_latch();
    chk_lvl("R9 shift took effect");

    // random mix
    for (int t = 0; t < 300; t++) begin
      case ($urandom_range(0, 5))
        0: begin dir_i = 2'($urandom()); idle(2); chk_pins("R7 random dir"); end
        1: do_latch();
        2: do_both(2'($urandom()), 2'($urandom()));
        3: set_alt(1'($urandom()));
        default: begin do_shift(2'($urandom()), 2'($urandom())); chk_pins("R8 random shift"); end
      endcase
      chk_lvl("R5 R6 R9 random");
    end

    finish_run();
  end
endmodule